// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block holds the two byte queues that sit between software and the serial transfer engine of an SPI controller, together with the controller's interrupt logic. Software loads outgoing bytes into the transmit queue and unloads received bytes from the receive queue through a small word-wide register port. The transfer engine takes bytes from the head of the transmit queue and deposits received bytes into the receive queue. Serial shifting and clock generation live elsewhere.

Each queue is 128 bytes deep. Each queue tracks its occupancy with a three-state machine: `FS_EMPTY`, `FS_FILL` and `FS_FULL`. The transitions are `EMPTY->FILL` on an accepted push, `FILL->FULL` on a push that takes the count to the depth, `FILL->EMPTY` on a pop that takes the count to zero, `FULL->FILL` on an accepted pop, and `any->EMPTY` on a flush. The level register reports each count in a 7-bit field that saturates at 127, so a full queue and a queue with one free slot read the same; the state machine still tells them apart internally.

The interrupt part latches two events: a receive push that arrives while the receive queue is full, and a transfer-complete pulse from the engine. Both flags are cleared by writing one to them. The single interrupt line is high while any latched flag has its enable bit set.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset both queues are empty, the level, enable and pending registers read 0, `irq` is low, `sw_rdata` is 0 and `tx_byte` is 0.
- R2: Both queues are first-in first-out. A software write to address 4 loads `sw_wdata[7:0]` into the transmit queue, which `tx_byte` presents at its head. A `rx_push` of `rx_byte` is returned in `sw_rdata[7:0]` by a read of address 5, with the upper bits at 0.
- R3: A read of address 1 returns the receive count in bits 6:0 and the transmit count in bits 22:16. All other bits are 0. Each count is the occupancy, capped at 127.
- R4: Each queue accepts 128 bytes and returns all of them in order. A software write to address 4 while the transmit queue holds 128 bytes is dropped.
- R5: A `rx_push` while the receive queue holds 128 bytes sets pending bit 8 (receive overflow). The byte is dropped and the queue contents are unchanged.
- R6: A write to address 0 with bit 15 set empties the receive queue, and bit 31 set empties the transmit queue, at the edge of the write. The other queue is left untouched. A push in the same cycle as the flush of its queue is discarded. Address 0 always reads 0.
- R7: With the transmit queue empty, `tx_byte` is 0. A read of address 5 with the receive queue empty returns 0. A pop from an empty queue leaves its count at 0.
- R8: A `xfer_done` pulse sets pending bit 12 (transfer complete).
- R9: Writing to address 3 clears each pending bit whose `sw_wdata` bit is 1, and writing all ones clears both. An event in the same cycle as the clear of its bit leaves that bit set.
- R10: Address 2 holds the enable bits 8 and 12, and its other bits read 0. Pending bits latch whatever the enables are set to. `irq` is high exactly when some pending bit has its enable set.
- R11: `sw_rdata` is loaded at each clock edge where `sw_rd` is sampled high and holds its value otherwise. A register that has no read meaning, address 4 included, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr | input | 1 | Software write strobe |
| sw_rd | input | 1 | Software read strobe |
| sw_addr | input | 3 | Register address: 0 queue control, 1 level, 2 enable, 3 pending, 4 transmit data, 5 receive data |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Read data, registered |
| tx_pop | input | 1 | Engine takes the transmit head |
| tx_byte | output | 8 | Transmit head byte, 0 when empty |
| rx_push | input | 1 | Engine deposits a received byte |
| rx_byte | input | 8 | Received byte |
| xfer_done | input | 1 | Transfer-complete pulse from the engine |
| irq | output | 1 | Interrupt request |

## Verification
Every write, push, pop, flush and event takes effect at the clock edge where it is sampled. Its result is therefore visible in the cycle that follows. `irq` follows pending and enable without a further register, in that same cycle. A read returns in `sw_rdata` the state just before the edge that sampled `sw_rd`. The bench therefore drives its inputs one nanosecond after a rising edge and reads results one nanosecond after the next one. A scoreboard queue holds the expected bytes for each direction. A monitor compares `tx_byte` at the falling edge of every cycle in which the bench pops, which is before that pop lands.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int LVL_W   = 7;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LEVEL = 3'd1;
    localparam logic [ADDR_W-1:0] A_EN    = 3'd2;
    localparam logic [ADDR_W-1:0] A_PEND  = 3'd3;
    localparam logic [ADDR_W-1:0] A_TX    = 3'd4;
    localparam logic [ADDR_W-1:0] A_RX    = 3'd5;

    localparam int RX_FLUSH_BIT = 15;
    localparam int TX_FLUSH_BIT = 31;
    localparam int OVF_BIT      = 8;
    localparam int DONE_BIT     = 12;
    localparam int RX_LVL_LSB   = 0;
    localparam int TX_LVL_LSB   = 16;

    localparam int EV_OVF  = 0;
    localparam int EV_DONE = 1;
    localparam int NUM_EV  = 2;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_FILL  = 2'd1,
        FS_FULL  = 2'd2
    } fifo_state_e;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo
    import spi_fifo_irq_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     pop_data,
    output logic [CNT_W-1:0] occ,
    output logic             push_drop
);

    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [PTR_W-1:0] P_END = PTR_W'(DEPTH - 1);

    fifo_state_e state_q, state_d;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] occ_q;
    logic [W-1:0]     mem [DEPTH];
    logic             is_full, is_empty;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == P_END) ? '0 : p + PTR_W'(1);
    endfunction

    // outputs of the occupancy state machine
    always_comb begin
        is_full  = (state_q == FS_FULL);
        is_empty = (state_q == FS_EMPTY);
    end

    assign do_push = push && !is_full && !flush;
    assign do_pop  = pop && !is_empty && !flush;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_EMPTY: begin
                if (do_push) state_d = (DEPTH == 1) ? FS_FULL : FS_FILL;
            end
            FS_FILL: begin
                if (do_push && !do_pop && occ_q == LAST)
                    state_d = FS_FULL;
                else if (do_pop && !do_push && occ_q == ONE)
                    state_d = FS_EMPTY;
            end
            FS_FULL: begin
                if (do_pop) state_d = (DEPTH == 1) ? FS_EMPTY : FS_FILL;
            end
            default: state_d = FS_EMPTY;
        endcase
        if (flush) state_d = FS_EMPTY;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ_q  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      occ_q <= occ_q + ONE;
            else if (do_pop && !do_push) occ_q <= occ_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    assign pop_data  = is_empty ? '0 : mem[rd_ptr];
    assign occ       = occ_q;
    assign push_drop = push && is_full;

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_fifo_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] event_set,
    input  logic              en_wr,
    input  logic              pend_wr,
    input  logic [NUM_EV-1:0] wbits,
    output logic [NUM_EV-1:0] pend,
    output logic [NUM_EV-1:0] en,
    output logic              irq
);

    logic [NUM_EV-1:0] pend_q, en_q, clr;

    assign clr = pend_wr ? wbits : '0;

    // a fresh event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= event_set | (pend_q & ~clr);
            if (en_wr) en_q <= wbits;
        end
    end

    assign pend = pend_q;
    assign en   = en_q;
    assign irq  = |(pend_q & en_q);

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import spi_fifo_irq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic              sw_rd,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              xfer_done,
    output logic              irq
);

    localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'((1 << LVL_W) - 1);

    logic [CNT_W-1:0]  rx_occ, tx_occ;
    logic [BYTE_W-1:0] rx_head;
    logic              rx_drop, tx_drop_unused;
    logic              rx_flush, tx_flush, tx_load, rx_take;
    logic [NUM_EV-1:0] irq_pend, irq_en, ev_set, ev_bits;
    logic [DATA_W-1:0] rd_mux;

    function automatic logic [LVL_W-1:0] cap_level(input logic [CNT_W-1:0] c);
        return (c > LVL_MAX) ? LVL_W'(LVL_MAX) : LVL_W'(c);
    endfunction

    assign rx_flush = sw_wr && sw_addr == A_CTRL && sw_wdata[RX_FLUSH_BIT];
    assign tx_flush = sw_wr && sw_addr == A_CTRL && sw_wdata[TX_FLUSH_BIT];
    assign tx_load  = sw_wr && sw_addr == A_TX;
    assign rx_take  = sw_rd && sw_addr == A_RX;

    spi_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) i_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (tx_load),
        .push_data (sw_wdata[BYTE_W-1:0]),
        .pop       (tx_pop),
        .pop_data  (tx_byte),
        .occ       (tx_occ),
        .push_drop (tx_drop_unused)
    );

    spi_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) i_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (rx_push),
        .push_data (rx_byte),
        .pop       (rx_take),
        .pop_data  (rx_head),
        .occ       (rx_occ),
        .push_drop (rx_drop)
    );

    always_comb begin
        ev_set           = '0;
        ev_set[EV_OVF]   = rx_drop;
        ev_set[EV_DONE]  = xfer_done;
        ev_bits          = '0;
        ev_bits[EV_OVF]  = sw_wdata[OVF_BIT];
        ev_bits[EV_DONE] = sw_wdata[DONE_BIT];
    end

    spi_irq_ctrl i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_set (ev_set),
        .en_wr     (sw_wr && sw_addr == A_EN),
        .pend_wr   (sw_wr && sw_addr == A_PEND),
        .wbits     (ev_bits),
        .pend      (irq_pend),
        .en        (irq_en),
        .irq       (irq)
    );

    always_comb begin
        rd_mux = '0;
        unique case (sw_addr)
            A_LEVEL: begin
                rd_mux[RX_LVL_LSB +: LVL_W] = cap_level(rx_occ);
                rd_mux[TX_LVL_LSB +: LVL_W] = cap_level(tx_occ);
            end
            A_EN: begin
                rd_mux[OVF_BIT]  = irq_en[EV_OVF];
                rd_mux[DONE_BIT] = irq_en[EV_DONE];
            end
            A_PEND: begin
                rd_mux[OVF_BIT]  = irq_pend[EV_OVF];
                rd_mux[DONE_BIT] = irq_pend[EV_DONE];
            end
            A_RX:    rd_mux[BYTE_W-1:0] = rx_head;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sw_rdata <= '0;
        else if (sw_rd) sw_rdata <= rd_mux;
    end

endmodule

// File: rtl/spi_fifo_irq_checker.sv
module spi_fifo_irq_checker
    import spi_fifo_irq_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CNT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_wr,
    input logic              sw_rd,
    input logic [ADDR_W-1:0] sw_addr,
    input logic [DATA_W-1:0] sw_wdata,
    input logic [DATA_W-1:0] sw_rdata,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              rx_push,
    input logic              xfer_done,
    input logic              irq,
    input logic [CNT_W-1:0]  rx_occ,
    input logic [CNT_W-1:0]  tx_occ,
    input logic [NUM_EV-1:0] irq_pend,
    input logic [NUM_EV-1:0] irq_en
);

    a_r4_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_occ <= CNT_W'(DEPTH)) && (tx_occ <= CNT_W'(DEPTH)));

    a_r5_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_occ == CNT_W'(DEPTH)) |=> irq_pend[EV_OVF]);

    a_r6_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && sw_addr == A_CTRL && sw_wdata[RX_FLUSH_BIT]) |=> (rx_occ == '0));

    a_r7_empty_head_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_occ == '0) |-> (tx_byte == '0));

    a_r8_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> irq_pend[EV_DONE]);

    a_r10_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rd |=> $stable(sw_rdata));

endmodule

bind spi_fifo_irq_unit spi_fifo_irq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_wr     (sw_wr),
    .sw_rd     (sw_rd),
    .sw_addr   (sw_addr),
    .sw_wdata  (sw_wdata),
    .sw_rdata  (sw_rdata),
    .tx_byte   (tx_byte),
    .rx_push   (rx_push),
    .xfer_done (xfer_done),
    .irq       (irq),
    .rx_occ    (rx_occ),
    .tx_occ    (tx_occ),
    .irq_pend  (irq_pend),
    .irq_en    (irq_en)
);

// File: tb/test_spi_fifo_irq_unit.sv
`timescale 1ns/1ps
module test_spi_fifo_irq_unit;
    import spi_fifo_irq_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sw_wr = 1'b0, sw_rd = 1'b0;
    logic [ADDR_W-1:0] sw_addr = '0;
    logic [DATA_W-1:0] sw_wdata = '0;
    logic [DATA_W-1:0] sw_rdata;
    logic              tx_pop = 1'b0;
    logic [BYTE_W-1:0] tx_byte;
    logic              rx_push = 1'b0;
    logic [BYTE_W-1:0] rx_byte = '0;
    logic              xfer_done = 1'b0;
    logic              irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];

    always #2 clk = ~clk;

    spi_fifo_irq_unit i_spi_fifo_irq_unit (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_rd(sw_rd),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .rx_push(rx_push),
        .rx_byte(rx_byte), .xfer_done(xfer_done), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: transmit head checked before the pop edge (R2, R4, R7)
    always @(negedge clk) begin
        if (tx_pop && rst_n) begin
            logic [7:0] e;
            e = (exp_tx.size() > 0) ? exp_tx.pop_front() : 8'h00;
            chk("R2 tx head order", {24'h0, tx_byte}, {24'h0, e});
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic sw_write(input logic [2:0] a, input logic [31:0] d);
        sw_wr = 1'b1; sw_addr = a; sw_wdata = d;
        tick();
        sw_wr = 1'b0; sw_wdata = '0;
    endtask

    task automatic sw_read(input logic [2:0] a, output logic [31:0] d);
        sw_rd = 1'b1; sw_addr = a;
        tick();
        sw_rd = 1'b0;
        d = sw_rdata;
    endtask

    task automatic tx_load(input logic [7:0] b, input bit accept);
        if (accept) exp_tx.push_back(b);
        sw_write(A_TX, {24'h0, b});
    endtask

    task automatic tx_pull();
        tx_pop = 1'b1;
        tick();
        tx_pop = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b, input bit accept);
        if (accept) exp_rx.push_back(b);
        rx_push = 1'b1; rx_byte = b;
        tick();
        rx_push = 1'b0;
    endtask

    task automatic rx_take(input string tag);
        logic [31:0] d;
        logic [7:0] e;
        e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 8'h00;
        sw_read(A_RX, d);
        chk(tag, d, {24'h0, e});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 rdata", sw_rdata, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 tx_byte", {24'h0, tx_byte}, 32'h0);
        sw_read(A_LEVEL, d); chk("R1 level", d, 32'h0);
        sw_read(A_EN, d);    chk("R1 enable", d, 32'h0);
        sw_read(A_PEND, d);  chk("R1 pending", d, 32'h0);

        // R2/R3 short transmit traffic
        tx_load(8'hA1, 1); tx_load(8'hB2, 1); tx_load(8'hC3, 1);
        sw_read(A_LEVEL, d); chk("R3 tx level 3", d, 32'h0003_0000);
        sw_read(A_TX, d);    chk("R11 tx addr reads 0", d, 32'h0);
        repeat (3) tx_pull();
        tx_pull();  // R7 pop from empty, head 0
        sw_read(A_LEVEL, d); chk("R7 tx level stays 0", d, 32'h0);

        // R2/R3 receive traffic
        rx_send(8'h11, 1); rx_send(8'h22, 1); rx_send(8'h33, 1);
        rx_send(8'h44, 1); rx_send(8'h55, 1);
        sw_read(A_LEVEL, d); chk("R3 rx level 5", d, 32'h0000_0005);
        repeat (5) rx_take("R2 rx order");
        rx_take("R7 rx empty reads 0");
        sw_read(A_LEVEL, d); chk("R7 rx level stays 0", d, 32'h0);

        // R11 hold: state changes without a read leave rdata alone
        tx_load(8'h77, 1);
        chk("R11 rdata held", sw_rdata, 32'h0);
        tx_pull();

        // R4 full transmit queue
        for (int i = 0; i < 128; i++) tx_load(8'(i * 3 + 1), 1);
        sw_read(A_LEVEL, d); chk("R3 R4 tx level capped", d, 32'h007F_0000);
        tx_load(8'hEE, 0);
        for (int i = 0; i < 128; i++) tx_pull();
        sw_read(A_LEVEL, d); chk("R4 tx drained, 129th dropped", d, 32'h0);

        // R4/R5 full receive queue and overflow
        for (int i = 0; i < 128; i++) rx_send(8'(255 - i), 1);
        sw_read(A_LEVEL, d); chk("R4 rx level capped", d, 32'h0000_007F);
        sw_read(A_PEND, d);  chk("R5 no overflow yet", d, 32'h0);
        rx_send(8'h5A, 0);
        sw_read(A_PEND, d);  chk("R5 overflow pending", d, 32'h0000_0100);
        chk("R10 irq off when disabled", {31'h0, irq}, 32'h0);
        for (int i = 0; i < 128; i++) rx_take("R5 rx contents intact");
        rx_take("R5 dropped byte absent");
        sw_write(A_PEND, 32'hFFFF_FFFF);

        // R6 flushes
        tx_load(8'h01, 1); tx_load(8'h02, 1); tx_load(8'h03, 1);
        rx_send(8'h0A, 1); rx_send(8'h0B, 1);
        sw_write(A_CTRL, 32'h0000_8000); exp_rx.delete();
        sw_read(A_LEVEL, d); chk("R6 rx flush only", d, 32'h0003_0000);
        sw_read(A_CTRL, d);  chk("R6 ctrl reads 0", d, 32'h0);
        sw_write(A_CTRL, 32'h8000_0000); exp_tx.delete();
        sw_read(A_LEVEL, d); chk("R6 tx flush", d, 32'h0);
        rx_push = 1'b1; rx_byte = 8'h99;
        sw_write(A_CTRL, 32'h0000_8000);
        rx_push = 1'b0;
        sw_read(A_LEVEL, d); chk("R6 flush beats push", d, 32'h0);

        // R8/R9/R10 interrupts
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        sw_read(A_PEND, d); chk("R8 done pending", d, 32'h0000_1000);
        chk("R10 irq off with enables 0", {31'h0, irq}, 32'h0);
        sw_write(A_EN, 32'hFFFF_FFFF);
        sw_read(A_EN, d); chk("R10 enable readback", d, 32'h0000_1100);
        chk("R10 irq on", {31'h0, irq}, 32'h1);
        rx_send(8'h00, 1);  // queue not full: no overflow
        sw_write(A_PEND, 32'h0000_1000);
        sw_read(A_PEND, d); chk("R9 clear done only", d, 32'h0);
        chk("R10 irq off after clear", {31'h0, irq}, 32'h0);
        xfer_done = 1'b1;
        sw_write(A_PEND, 32'h0000_1000);
        xfer_done = 1'b0;
        sw_read(A_PEND, d); chk("R9 event beats clear", d, 32'h0000_1000);
        sw_write(A_EN, 32'h0000_0100);
        chk("R10 masked done gives no irq", {31'h0, irq}, 32'h0);
        sw_write(A_EN, 32'h0000_1000);
        chk("R10 irq with done enabled", {31'h0, irq}, 32'h1);
        sw_write(A_PEND, 32'hFFFF_FFFF);
        sw_read(A_PEND, d); chk("R9 all ones clears", d, 32'h0);
        chk("R9 irq low", {31'h0, irq}, 32'h0);
        rx_take("R2 rx after traffic");

        finish_run();
    end

endmodule